// File: doc/BRIEF.md
# Segment Register File with Descriptor Cache

This block keeps six segment registers for an address-translation front end. Each register pairs a visible 16-bit selector with a hidden copy of the descriptor behind it: a 32-bit base, a 32-bit limit and 8 access bits. The register file never reads descriptor tables itself. The surrounding pipeline fetches the descriptor and presents it on the load port together with the selector and a register index. The block then accepts the load, or refuses it with a general-protection fault.

The access port takes a register index and a 32-bit offset. It returns the linear address, built from the cached base alone, along with a null-selector fault and a limit fault. A null selector is a selector whose table flag and descriptor index are both zero. The code and stack registers refuse it at load time. The four data registers accept it, and a null-selector fault is raised only when one of them is used for an access. Privilege checks against the running level and reloads after table edits are left to other blocks.

Top module: `segfile_top`

## Requirements
- R1: The file holds six independent registers selected by index: 0 code, 1 stack, 2 data, 3 first extra, 4 second extra, 5 third extra. A load to one index leaves every other index unchanged.
- R2: After reset, every register holds selector 0, base 0, limit 0 and access bits 0, and every output is 0.
- R3: A selector is null when bits 15:3 (the descriptor index) and bit 2 (the table flag) are all zero. Bits 1:0 (the requested privilege level, 0 most privileged) do not affect this test.
- R4: Loading a null selector into index 0 or 1 sets the load fault output, and that register keeps its previous selector, base, limit and access bits.
- R5: Loading a null selector into index 2, 3, 4 or 5 is accepted with the load fault output clear.
- R6: An accepted load writes the selector, base, limit and access bits in the same clock edge. A later access returns that selector on the access selector output and those bits on the access-bits output.
- R7: The linear address equals the cached base plus the offset, modulo 2^32.
- R8: The limit fault output is set when the offset exceeds the cached limit. An offset equal to the limit does not raise it.
- R9: The null fault output is set for an access through a register whose selector is null.
- R10: The load and access results (done, fault flags, address, selector, access bits) appear one clock after their valid strobe. The done and fault outputs are 0 in a cycle that follows no strobe. The address, selector and access-bits outputs hold their last value.
- R11: An access in the same cycle as a load to the same register sees the contents from before that load.
- R12: A load with index 6 or 7 raises the load fault and changes nothing. An access with index 6 or 7 behaves as an access to a register in its reset state.
- R13: Translation uses only the cached fields. Load-port inputs that change without a load strobe do not affect the access results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ldValid | input | 1 | Load strobe |
| ldIdx | input | 3 | Target register index |
| ldSel | input | 16 | Selector to load |
| ldBase | input | 32 | Descriptor base |
| ldLimit | input | 32 | Descriptor limit |
| ldAcc | input | 8 | Descriptor access bits |
| ldDone | output | 1 | Load result valid |
| ldFault | output | 1 | General-protection fault on load |
| acValid | input | 1 | Access strobe |
| acIdx | input | 3 | Register index used for the access |
| acOffset | input | 32 | Offset within the segment |
| acDone | output | 1 | Access result valid |
| acLinear | output | 32 | Linear address |
| acSel | output | 16 | Selector held by the accessed register |
| acAccess | output | 8 | Access bits held by the accessed register |
| acNullFault | output | 1 | Access through a null selector |
| acLimitFault | output | 1 | Offset above the cached limit |

## Verification
The bench loads a selector with a nonzero privilege field but zero index and zero table flag into the code register. A design that tested all sixteen bits for zero would accept that load instead of faulting. A selector with only the table flag set is then loaded, and a design that ignored bit 2 would fault on it wrongly. An offset equal to the limit and one just above it are both used, so an off-by-one in the comparison shows up as a wrong fault. A base near the top of the address space checks that the sum wraps. A load and an access to the same register in one cycle checks that the access does not see the new base through a forwarding path. Loads to indices 6 and 7, and load inputs that change without a strobe, check that no write slips through.

// File: rtl/segfile_pkg.sv
package segfile_pkg;
  localparam int SEL_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int ACC_W   = 8;
  localparam int NUM_SEG = 6;
  localparam int IDX_W   = $clog2(NUM_SEG + 1);
  localparam int CODE_IDX  = 0;
  localparam int STACK_IDX = 1;
  localparam int NULL_LSB  = 2; // selector bits from here upward must be zero for a null selector

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ACC_W-1:0]  acc;
  } segEntry_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
  } segCtrl_t;

  function automatic logic isNullSel(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1:NULL_LSB] == '0;
  endfunction
endpackage

// File: rtl/segfile_ctrl.sv
module segfile_ctrl
  import segfile_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldValid,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [SEL_W-1:0] ldSel,
  output segCtrl_t         strobe,
  output logic             ldDone,
  output logic             ldFault
);
  logic idxOk;
  logic needsLive;
  logic rejected;

  always_comb begin
    idxOk     = int'(ldIdx) < NUM_SEG;
    needsLive = (ldIdx == IDX_W'(CODE_IDX)) || (ldIdx == IDX_W'(STACK_IDX));
    rejected  = !idxOk || (needsLive && isNullSel(ldSel));
    strobe.wrEn  = ldValid && !rejected;
    strobe.wrIdx = ldIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldDone  <= 1'b0;
      ldFault <= 1'b0;
    end else begin
      ldDone  <= ldValid;
      ldFault <= ldValid && rejected;
    end
  end

  AST_LIVE_NULL_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && int'(ldIdx) <= STACK_IDX && ldSel[SEL_W-1:NULL_LSB] == '0) |=> ldFault) // R4
    else $error("null load into code/stack not faulted");
  AST_DATA_NULL_OK: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && int'(ldIdx) > STACK_IDX && int'(ldIdx) < NUM_SEG) |=> !ldFault) // R5
    else $error("data register load faulted");
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && int'(ldIdx) >= NUM_SEG) |-> !strobe.wrEn) // R12
    else $error("out-of-range load wrote");
endmodule

// File: rtl/segfile_dp.sv
module segfile_dp
  import segfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  segCtrl_t          strobe,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [ADDR_W-1:0] ldLimit,
  input  logic [ACC_W-1:0]  ldAcc,
  input  logic              acValid,
  input  logic [IDX_W-1:0]  acIdx,
  input  logic [ADDR_W-1:0] acOffset,
  output logic              acDone,
  output logic [ADDR_W-1:0] acLinear,
  output logic [SEL_W-1:0]  acSel,
  output logic [ACC_W-1:0]  acAccess,
  output logic              acNullFault,
  output logic              acLimitFault
);
  segEntry_t newEntry;
  segEntry_t rdEntry;
  segEntry_t entryQ [NUM_SEG];

  always_comb begin
    newEntry.sel   = ldSel;
    newEntry.base  = ldBase;
    newEntry.limit = ldLimit;
    newEntry.acc   = ldAcc;
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entryQ[i] <= '0;
      else if (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) entryQ[i] <= newEntry;
    end

    AST_HOLD_UNLESS_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wrEn && strobe.wrIdx == IDX_W'(i)) |=> $stable(entryQ[i])) // R1
      else $error("segment %0d changed without a write", i);
    AST_CAPTURE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) |=> entryQ[i] == $past(newEntry)) // R6
      else $error("segment %0d did not capture all fields", i);
  end

  always_comb begin
    rdEntry = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (int'(acIdx) == i) rdEntry = entryQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acDone       <= 1'b0;
      acLinear     <= '0;
      acSel        <= '0;
      acAccess     <= '0;
      acNullFault  <= 1'b0;
      acLimitFault <= 1'b0;
    end else begin
      acDone       <= acValid;
      acNullFault  <= acValid && isNullSel(rdEntry.sel);
      acLimitFault <= acValid && (acOffset > rdEntry.limit);
      if (acValid) begin
        acLinear <= rdEntry.base + acOffset;
        acSel    <= rdEntry.sel;
        acAccess <= rdEntry.acc;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    acValid |=> acDone) // R10
    else $error("access result late");
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !acValid |=> (!acNullFault && !acLimitFault && $stable(acLinear))) // R10
    else $error("access outputs moved without a strobe");
endmodule

// File: rtl/segfile_top.sv
module segfile_top
  import segfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [ADDR_W-1:0] ldLimit,
  input  logic [ACC_W-1:0]  ldAcc,
  output logic              ldDone,
  output logic              ldFault,
  input  logic              acValid,
  input  logic [IDX_W-1:0]  acIdx,
  input  logic [ADDR_W-1:0] acOffset,
  output logic              acDone,
  output logic [ADDR_W-1:0] acLinear,
  output logic [SEL_W-1:0]  acSel,
  output logic [ACC_W-1:0]  acAccess,
  output logic              acNullFault,
  output logic              acLimitFault
);
  segCtrl_t strobe;

  segfile_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldValid (ldValid),
    .ldIdx   (ldIdx),
    .ldSel   (ldSel),
    .strobe  (strobe),
    .ldDone  (ldDone),
    .ldFault (ldFault)
  );

  segfile_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ldSel        (ldSel),
    .ldBase       (ldBase),
    .ldLimit      (ldLimit),
    .ldAcc        (ldAcc),
    .acValid      (acValid),
    .acIdx        (acIdx),
    .acOffset     (acOffset),
    .acDone       (acDone),
    .acLinear     (acLinear),
    .acSel        (acSel),
    .acAccess     (acAccess),
    .acNullFault  (acNullFault),
    .acLimitFault (acLimitFault)
  );
endmodule

// File: tb/test_segfile_top.sv
module test_segfile_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [2:0]  ldIdx = '0;
  logic [15:0] ldSel = '0;
  logic [31:0] ldBase = '0, ldLimit = '0;
  logic [7:0]  ldAcc = '0;
  logic        ldDone, ldFault;
  logic        acValid = 1'b0;
  logic [2:0]  acIdx = '0;
  logic [31:0] acOffset = '0;
  logic        acDone, acNullFault, acLimitFault;
  logic [31:0] acLinear;
  logic [15:0] acSel;
  logic [7:0]  acAccess;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit started = 1'b0;

  // behavioural reference state
  logic [15:0] mSel [6];
  logic [31:0] mBase [6];
  logic [31:0] mLim [6];
  logic [7:0]  mAcc [6];
  logic        eLdDone, eLdFault, eAcDone, eNull, eLim;
  logic [31:0] eLin;
  logic [15:0] eSel;
  logic [7:0]  eAcc;

  always #2 clk = ~clk;

  segfile_top i_segfile_top (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldIdx(ldIdx), .ldSel(ldSel), .ldBase(ldBase),
    .ldLimit(ldLimit), .ldAcc(ldAcc), .ldDone(ldDone), .ldFault(ldFault),
    .acValid(acValid), .acIdx(acIdx), .acOffset(acOffset), .acDone(acDone),
    .acLinear(acLinear), .acSel(acSel), .acAccess(acAccess),
    .acNullFault(acNullFault), .acLimitFault(acLimitFault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 6; i++) begin
        mSel[i] = '0; mBase[i] = '0; mLim[i] = '0; mAcc[i] = '0;
      end
      {eLdDone, eLdFault, eAcDone, eNull, eLim} = '0;
      eLin = '0; eSel = '0; eAcc = '0;
    end else begin
      logic [15:0] s; logic [31:0] b, l; logic [7:0] a;
      started = 1'b1;
      eAcDone = acValid;
      if (acIdx < 6) begin
        s = mSel[acIdx]; b = mBase[acIdx]; l = mLim[acIdx]; a = mAcc[acIdx];
      end else begin
        s = '0; b = '0; l = '0; a = '0;
      end
      eNull = acValid && (s[15:2] == 0);
      eLim  = acValid && (acOffset > l);
      if (acValid) begin
        eLin = b + acOffset; eSel = s; eAcc = a;
      end
      eLdDone  = ldValid;
      eLdFault = ldValid && (ldIdx > 5 || (ldIdx < 2 && ldSel[15:2] == 0));
      if (ldValid && !eLdFault) begin
        mSel[ldIdx] = ldSel; mBase[ldIdx] = ldBase; mLim[ldIdx] = ldLimit; mAcc[ldIdx] = ldAcc;
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && rstN && !finished) begin
      chk("R10 model ldDone", 32'(ldDone), 32'(eLdDone));
      chk("R10 model acDone", 32'(acDone), 32'(eAcDone));
      chk("R4 model ldFault", 32'(ldFault), 32'(eLdFault));
      chk("R9 model acNullFault", 32'(acNullFault), 32'(eNull));
      chk("R8 model acLimitFault", 32'(acLimitFault), 32'(eLim));
      chk("R7 model acLinear", acLinear, eLin);
      chk("R6 model acSel", 32'(acSel), 32'(eSel));
      chk("R6 model acAccess", 32'(acAccess), 32'(eAcc));
    end
  end

  task automatic doLoad(input logic [2:0] idx, input logic [15:0] sel, input logic [31:0] base,
                        input logic [31:0] lim, input logic [7:0] acc);
    ldIdx = idx; ldSel = sel; ldBase = base; ldLimit = lim; ldAcc = acc; ldValid = 1'b1;
  endtask

  task automatic doAcc(input logic [2:0] idx, input logic [31:0] off);
    acIdx = idx; acOffset = off; acValid = 1'b1;
  endtask

  task automatic tick();
    @(negedge clk);
    ldValid = 1'b0;
    acValid = 1'b0;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R2 reset ldDone", 32'(ldDone), 0);
    chk("R2 reset acDone", 32'(acDone), 0);
    chk("R2 reset acLinear", acLinear, 0);
    doAcc(3'd2, 32'h0); tick();
    chk("R2 reset selector", 32'(acSel), 0);
    chk("R9 reset null fault", 32'(acNullFault), 1);
    chk("R2 reset limit zero", 32'(acLimitFault), 0);

    doLoad(3'd0, 16'h0008, 32'h0000_1000, 32'h0000_FFFF, 8'h9A); tick();
    chk("R5 code load ok", 32'(ldFault), 0);
    doAcc(3'd0, 32'h20); tick();
    chk("R7 linear", acLinear, 32'h0000_1020);
    chk("R6 selector", 32'(acSel), 32'h0008);
    chk("R6 access bits", 32'(acAccess), 32'h9A);

    doLoad(3'd0, 16'h0003, 32'hAAAA_0000, 32'h1, 8'h11); tick();
    chk("R3 R4 null with rpl faults", 32'(ldFault), 1);
    doAcc(3'd0, 32'h20); tick();
    chk("R4 code kept", acLinear, 32'h0000_1020);
    chk("R4 code sel kept", 32'(acSel), 32'h0008);

    doLoad(3'd1, 16'h0004, 32'h0000_2000, 32'hFF, 8'h92); tick();
    chk("R3 table flag not null", 32'(ldFault), 0);
    doAcc(3'd1, 32'h4); tick();
    chk("R3 table flag access", 32'(acNullFault), 0);

    doLoad(3'd3, 16'h0002, 32'h5, 32'h10, 8'h0); tick();
    chk("R5 data null accepted", 32'(ldFault), 0);
    doAcc(3'd3, 32'h1); tick();
    chk("R9 null use faults", 32'(acNullFault), 1);
    chk("R5 data null sel", 32'(acSel), 32'h0002);

    doLoad(3'd5, 16'h0010, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 8'h93); tick();
    doAcc(3'd5, 32'h20); tick();
    chk("R7 wrap", acLinear, 32'h0000_0010);
    doAcc(3'd4, 32'h0); tick();
    chk("R1 neighbour untouched", 32'(acNullFault), 1);

    doLoad(3'd2, 16'h0018, 32'h100, 32'h40, 8'h92); tick();
    doAcc(3'd2, 32'h40); tick();
    chk("R8 offset equals limit", 32'(acLimitFault), 0);
    doAcc(3'd2, 32'h41); tick();
    chk("R8 offset above limit", 32'(acLimitFault), 1);

    doLoad(3'd6, 16'h0020, 32'h7, 32'h7, 8'h7); tick();
    chk("R12 bad index load", 32'(ldFault), 1);
    doAcc(3'd7, 32'h33); tick();
    chk("R12 bad index null", 32'(acNullFault), 1);
    chk("R12 bad index linear", acLinear, 32'h33);

    doLoad(3'd2, 16'h0018, 32'h900, 32'h40, 8'h92); doAcc(3'd2, 32'h0); tick();
    chk("R11 same-cycle old base", acLinear, 32'h100);
    ldBase = 32'hDEAD_0000; ldLimit = 32'h0;
    doAcc(3'd2, 32'h4); tick();
    chk("R11 new base visible", acLinear, 32'h904);
    chk("R13 unstrobed inputs ignored", 32'(acLimitFault), 0);

    tick();
    chk("R10 idle acDone", 32'(acDone), 0);
    chk("R10 idle ldDone", 32'(ldDone), 0);
    chk("R10 idle holds linear", acLinear, 32'h904);
    finishRun();
  end
endmodule